// File: doc/BRIEF.md
# Slice-Serial Big-Endian Counter Incrementer

This block adds one to a 128-bit counter that lives in an external set of IV registers, as used by counter-mode block encryption. Instead of one wide adder it uses a single 16-bit incrementer and walks the value one 16-bit slice per clock, least significant slice first. The carry out of each slice is kept in a flop and fed into the next, more significant slice. A full update takes eight cycles, which fits inside the round count of one cipher block, so the update runs next to the cipher without slowing it.

The block holds no copy of the counter. Each cycle it reads the current IV word bus, builds the new bytes for the active slice, and drives per-byte write enables. The surrounding register file stores those bytes, so the next slice sees an IV that is already partly updated. A one-cycle done pulse marks the end of an update. A new update may start in that same cycle.

Top module: `ctr_inc_engine`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `done_o` is low and every bit of `iv_we_o` is zero.
- R2: In the cycle after a start is accepted, the enables for slice 0 are high. Each following cycle moves to the next slice, for eight slices in total. Exactly two enable bits are high in each of those cycles and none in any other cycle.
- R3: Byte b of the counter sits at bits [8b+7:8b] of `iv_i`/`iv_o`, and byte 0 is the most significant byte of the 128-bit integer. Slice j is made of byte 15-2j (its low-order byte) and byte 14-2j (its high-order byte).
- R4: After the eight slices are written back, the stored IV equals its value at the accepted start plus one, modulo 2^128.
- R5: A carry out of a slice is added into the next more significant slice. A run of all-ones low slices becomes zeros and the first slice that is not all ones is incremented.
- R6: An IV of all ones wraps to all zeros with no other indication.
- R7: `done_o` is high for exactly one cycle. That cycle is the ninth cycle after the edge that accepted the start, and no enable is high in it.
- R8: A start that arrives while the eight slices are in progress is ignored. The run neither restarts nor adds a second increment.
- R9: Slices not yet processed stay unchanged in the stored IV. On `iv_o`, lanes whose enable is low carry `iv_i` unchanged.
- R10: A start present in the done cycle is accepted, so back-to-back updates run every nine cycles, and each adds one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for one increment, taken when not running |
| iv_i | input | 128 | Current IV register contents, byte b at bits [8b+7:8b] |
| iv_o | output | 128 | IV bytes with the active slice replaced by its incremented value |
| iv_we_o | output | 16 | Per-byte write enable for `iv_o` into the IV registers |
| done_o | output | 1 | One-cycle pulse after the last slice is written |

## Verification
The hardest case to reach from the ports is a carry that has to travel across many slices while the stored IV is only partly updated. Only all-ones low slices make every write-back differ from the old value. The stimulus therefore loads patterns whose low slices are all ones, with one pattern fully saturated. A bench-side register file applies the enables, and its contents are compared on every cycle against a behavioural integer model, including at a fixed mid-run point. Restarts are driven in the middle of a run and held through the done cycle, which covers both the rule that a busy start is ignored and the back-to-back case.

// File: rtl/ctr_inc_pkg.sv
package ctr_inc_pkg;

    localparam int unsigned DEF_CTR_W   = 128;
    localparam int unsigned DEF_SLICE_W = 16;
    localparam int unsigned BYTE_W      = 8;

    // Sequencer phases
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'b00,
        SEQ_RUN  = 2'b01,
        SEQ_DONE = 2'b10
    } seq_state_e;

    // Significance rank of a register byte lane: lane 0 is the most significant
    function automatic int unsigned lane_rank(int unsigned lane, int unsigned nbytes);
        return nbytes - 1 - lane;
    endfunction

    // Slice index that owns a byte lane (slice 0 is least significant)
    function automatic int unsigned lane_slice(int unsigned lane, int unsigned nbytes,
                                               int unsigned sbytes);
        return lane_rank(lane, nbytes) / sbytes;
    endfunction

    // Byte position of a lane inside its slice (0 is the low-order byte)
    function automatic int unsigned lane_offset(int unsigned lane, int unsigned nbytes,
                                                int unsigned sbytes);
        return lane_rank(lane, nbytes) % sbytes;
    endfunction

endpackage

// File: rtl/ctr_slice_adder.sv
module ctr_slice_adder #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    // Narrow incrementer: operand plus the carry held from the previous slice
    assign {cout_o, sum_o} = {1'b0, a_i} + {{W{1'b0}}, cin_i};
endmodule

// File: rtl/ctr_inc_seq.sv
module ctr_inc_seq
    import ctr_inc_pkg::*;
#(
    parameter int unsigned NUM_SLICES = 8,
    localparam int unsigned IDX_W     = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             run_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             load_o,
    output logic             done_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLICES - 1);

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    assign run_o  = (state_q == SEQ_RUN);
    assign done_o = (state_q == SEQ_DONE);
    assign idx_o  = idx_q;
    // A start is taken only when no slice walk is in progress
    assign load_o = start_i && (state_q != SEQ_RUN);

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            SEQ_IDLE, SEQ_DONE: begin
                if (start_i) begin
                    state_d = SEQ_RUN;
                    idx_d   = '0;
                end else begin
                    state_d = SEQ_IDLE;
                end
            end
            SEQ_RUN: begin
                if (idx_q == LAST_IDX) begin
                    state_d = SEQ_DONE;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            default: begin
                state_d = SEQ_IDLE;
                idx_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (run_o && idx_o == LAST_IDX) |=> done_o);

    // R8
    walk_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (run_o && idx_o != LAST_IDX) |=> (run_o && idx_o == IDX_W'($past(idx_o) + 1'b1)));

    // R10
    rearm_in_done_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && start_i) |=> (run_o && idx_o == '0));
endmodule

// File: rtl/ctr_lane_map.sv
module ctr_lane_map
    import ctr_inc_pkg::*;
#(
    parameter int unsigned CTR_W   = 128,
    parameter int unsigned SLICE_W = 16,
    localparam int unsigned NUM_BYTES   = CTR_W / BYTE_W,
    localparam int unsigned SLICE_BYTES = SLICE_W / BYTE_W,
    localparam int unsigned NUM_SLICES  = CTR_W / SLICE_W,
    localparam int unsigned IDX_W       = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
    input  logic [CTR_W-1:0]     iv_i,
    input  logic                 run_i,
    input  logic [IDX_W-1:0]     idx_i,
    input  logic [SLICE_W-1:0]   sum_i,
    output logic [SLICE_W-1:0]   slice_o,
    output logic [CTR_W-1:0]     iv_o,
    output logic [NUM_BYTES-1:0] we_o
);
    // Gather the active slice, swapping bytes from big-endian lane order
    always_comb begin
        slice_o = '0;
        for (int unsigned b = 0; b < NUM_BYTES; b++) begin
            if (idx_i == IDX_W'(lane_slice(b, NUM_BYTES, SLICE_BYTES))) begin
                slice_o[lane_offset(b, NUM_BYTES, SLICE_BYTES)*BYTE_W +: BYTE_W] =
                    iv_i[b*BYTE_W +: BYTE_W];
            end
        end
    end

    // Scatter the incremented slice back, one lane per byte
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
        localparam int unsigned SL  = lane_slice(g, NUM_BYTES, SLICE_BYTES);
        localparam int unsigned OFF = lane_offset(g, NUM_BYTES, SLICE_BYTES);
        assign we_o[g] = run_i && (idx_i == IDX_W'(SL));
        assign iv_o[g*BYTE_W +: BYTE_W] = we_o[g] ? sum_i[OFF*BYTE_W +: BYTE_W]
                                                  : iv_i[g*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/ctr_inc_engine.sv
module ctr_inc_engine
    import ctr_inc_pkg::*;
#(
    parameter int unsigned CTR_W   = DEF_CTR_W,
    parameter int unsigned SLICE_W = DEF_SLICE_W,
    localparam int unsigned NUM_BYTES  = CTR_W / BYTE_W,
    localparam int unsigned NUM_SLICES = CTR_W / SLICE_W,
    localparam int unsigned IDX_W      = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [CTR_W-1:0]     iv_i,
    output logic [CTR_W-1:0]     iv_o,
    output logic [NUM_BYTES-1:0] iv_we_o,
    output logic                 done_o
);
    logic               run;
    logic               load;
    logic [IDX_W-1:0]   idx;
    logic [SLICE_W-1:0] slice_val;
    logic [SLICE_W-1:0] slice_sum;
    logic               slice_cout;
    logic               carry_q;

    ctr_inc_seq #(.NUM_SLICES(NUM_SLICES)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start_i(start_i),
        .run_o  (run),
        .idx_o  (idx),
        .load_o (load),
        .done_o (done_o)
    );

    ctr_lane_map #(.CTR_W(CTR_W), .SLICE_W(SLICE_W)) u_map (
        .iv_i   (iv_i),
        .run_i  (run),
        .idx_i  (idx),
        .sum_i  (slice_sum),
        .slice_o(slice_val),
        .iv_o   (iv_o),
        .we_o   (iv_we_o)
    );

    ctr_slice_adder #(.W(SLICE_W)) u_add (
        .a_i   (slice_val),
        .cin_i (carry_q),
        .sum_o (slice_sum),
        .cout_o(slice_cout)
    );

    // Carry chain across cycles: seeded with the +1, then the slice carry-out
    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= 1'b0;
        end else if (load) begin
            carry_q <= 1'b1;
        end else if (run) begin
            carry_q <= slice_cout;
        end
    end

    // R2
    lane_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (iv_we_o == '0) || ($countones(iv_we_o) == SLICE_W / BYTE_W));

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (iv_we_o == '0));

    // R5
    carry_settled_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !carry_q) |=> !carry_q);

    // R9
    no_carry_same_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !carry_q) |-> (iv_o == iv_i));
endmodule

// File: tb/ctr_inc_engine_tb_top.sv
module ctr_inc_engine_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [127:0] iv_reg = '0;
    logic [127:0] iv_out;
    logic [15:0]  we;
    logic         done;
    logic         ld_en = 1'b0;
    logic [127:0] ld_val = '0;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    ctr_inc_engine dut_i (
        .clk    (clk),
        .rst    (rst),
        .start_i(start),
        .iv_i   (iv_reg),
        .iv_o   (iv_out),
        .iv_we_o(we),
        .done_o (done)
    );

    // Big-endian integer view: byte 0 is most significant (R3)
    function automatic logic [127:0] to_int(logic [127:0] r);
        logic [127:0] v = '0;
        for (int b = 0; b < 16; b++) v = {v[119:0], r[b*8 +: 8]};
        return v;
    endfunction

    function automatic logic [127:0] from_int(logic [127:0] v);
        logic [127:0] r;
        for (int b = 0; b < 16; b++) r[b*8 +: 8] = v[(15-b)*8 +: 8];
        return r;
    endfunction

    function automatic logic [127:0] bump(logic [127:0] r);
        return from_int(to_int(r) + 128'd1);
    endfunction

    function automatic logic [15:0] lanes_of(int j);
        logic [15:0] m = '0;
        m[15-2*j] = 1'b1;
        m[14-2*j] = 1'b1;
        return m;
    endfunction

    function automatic logic [127:0] take_slice(logic [127:0] base, logic [127:0] src, int j);
        logic [127:0] r = base;
        r[(15-2*j)*8 +: 8] = src[(15-2*j)*8 +: 8];
        r[(14-2*j)*8 +: 8] = src[(14-2*j)*8 +: 8];
        return r;
    endfunction

    task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Environment IV register file
    always @(posedge clk) begin
        if (ld_en) iv_reg <= ld_val;
        else for (int b = 0; b < 16; b++) if (we[b]) iv_reg[b*8 +: 8] <= iv_out[b*8 +: 8];
    end

    // Behavioural reference: phase 0 idle, 1..8 slice phase-1, 9 done
    int           phase = 0;
    logic [127:0] m_new = '0;
    logic [127:0] m_reg = '0;

    always @(posedge clk) begin
        if (ld_en) m_reg <= ld_val;
        else if (phase >= 1 && phase <= 8) m_reg <= take_slice(m_reg, m_new, phase - 1);
        if (rst) phase <= 0;
        else if ((phase == 0 || phase == 9) && start) begin
            phase <= 1;
            m_new <= bump(iv_reg);
        end else if (phase >= 1 && phase <= 8) phase <= phase + 1;
        else phase <= 0;
    end

    // Per-cycle comparison and watchdog
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            logic [15:0] exp_we;
            exp_we = (phase >= 1 && phase <= 8) ? lanes_of(phase - 1) : 16'h0;
            check(we == exp_we, "R2 enables", {112'h0, we}, {112'h0, exp_we});
            check(done == (phase == 9), "R7 done", {127'h0, done}, {127'h0, phase == 9});
            check(iv_reg == m_reg, "R9 stored IV", iv_reg, m_reg);
        end
        if (cyc > 50000) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 50000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic load_iv(logic [127:0] v);
        @(negedge clk); ld_en = 1'b1; ld_val = v;
        @(negedge clk); ld_en = 1'b0;
    endtask

    // Single increment with done timing checks; returns at N10
    task automatic run_one(logic [127:0] v, string req);
        load_iv(v);
        start = 1'b1;                 // N0
        @(negedge clk); start = 1'b0; // N1
        repeat (7) @(negedge clk);    // N8
        check(done == 1'b0, "R7 early", {127'h0, done}, 128'h0);
        @(negedge clk);               // N9
        check(done == 1'b1, "R7 pulse", {127'h0, done}, 128'h1);
        @(negedge clk);               // N10
        check(done == 1'b0, "R7 single", {127'h0, done}, 128'h0);
        check(iv_reg == bump(v), req, iv_reg, bump(v));
    endtask

    initial begin
        logic [127:0] v;
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check(done == 1'b0 && we == 16'h0, "R1 in reset", {we, done}, 128'h0);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && we == 16'h0, "R1 after reset", {we, done}, 128'h0);

        // R4: plain increment
        run_one(128'h0f0e0d0c_0b0a0908_07060504_03020100, "R4 plain");

        // R3: low byte is byte 15, carry lands in byte 14
        run_one({8'hFF, 8'h00, 112'h0}, "R3 byte order");
        check(iv_reg == {8'h00, 8'h01, 112'h0}, "R3 explicit", iv_reg, {8'h00, 8'h01, 112'h0});

        // R5: low twelve bytes all ones, bytes 0..3 = 12 34 56 78
        run_one({96'hFFFFFFFF_FFFFFFFF_FFFFFFFF, 32'h78563412}, "R5 carry");
        check(iv_reg == {96'h0, 32'h79563412}, "R5 explicit", iv_reg, {96'h0, 32'h79563412});

        // R6: wrap
        run_one({128{1'b1}}, "R6 wrap");
        check(iv_reg == 128'h0, "R6 zero", iv_reg, 128'h0);

        // R9: mid-run, two low slices written, rest untouched
        load_iv({128{1'b1}});
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        @(negedge clk);               // N3
        check(iv_reg == 128'h00000000_FFFFFFFF_FFFFFFFF_FFFFFFFF, "R9 mid-run",
              iv_reg, 128'h00000000_FFFFFFFF_FFFFFFFF_FFFFFFFF);
        repeat (8) @(negedge clk);

        // R8: start pulsed mid-run has no effect
        v = 128'h11111111_22222222_33333333_444444FF;
        load_iv(v);
        start = 1'b1;                 // N0
        @(negedge clk); start = 1'b0; // N1
        @(negedge clk);
        @(negedge clk); start = 1'b1; // N3
        @(negedge clk); start = 1'b0; // N4
        repeat (5) @(negedge clk);    // N9
        check(done == 1'b1, "R8 done unmoved", {127'h0, done}, 128'h1);
        @(negedge clk);
        check(iv_reg == bump(v), "R8 single add", iv_reg, bump(v));
        repeat (3) @(negedge clk);

        // R10: start held through done cycle -> second run back-to-back
        v = 128'hFEFFFFFF_00000000_ABCDEF01_FFFFFFFF;
        load_iv(v);
        start = 1'b1;                 // N0
        repeat (9) @(negedge clk);    // N9, done with start high
        check(done == 1'b1, "R10 first done", {127'h0, done}, 128'h1);
        @(negedge clk); start = 1'b0; // N10
        check(we == lanes_of(0), "R10 rerun", {112'h0, we}, {112'h0, lanes_of(0)});
        repeat (9) @(negedge clk);    // N19
        check(iv_reg == bump(bump(v)), "R10 two adds", iv_reg, bump(bump(v)));

        // R4: assorted patterns
        for (int k = 0; k < 6; k++) begin
            v = {$urandom, $urandom, $urandom, $urandom};
            if (k % 2 == 0) v[127:64] = '1;
            run_one(v, "R4 pattern");
        end

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule